// File: doc/BRIEF.md
# Parallel flash program/erase sequencer

This block is the host-side engine for an asynchronous parallel flash array built from several independent byte-wide devices sharing one address bus. A client hands it a single request: program a 32-bit word, erase one sector, or erase the whole array. Each request carries a mask of the byte lanes that take part. The sequencer then plays the fixed unlock-and-command write series onto the flash bus. Every write cycle is shaped in clock cycles from nanosecond parameters.

Once the last command write is issued, the sequencer switches to status polling. It repeatedly reads the target location with output enable. It compares bit 7 of every participating byte lane against the value the finished operation should leave behind. It ends with a one-clock acknowledge that carries pass or fail. A read budget bounds the polling, and running out of it raises a timeout flag.

The states are IDLE, WSETUP (address, data and chip select presented, strobe high), WLOW (write strobe low), WHIGH (strobe high, address held), PGAP (output enable high before a read), PREAD (output enable low, sampled on its last cycle) and DONE (acknowledge). The transitions are:
- IDLE→WSETUP: a request is accepted.
- IDLE→DONE: a request is rejected.
- WSETUP→WLOW→WHIGH: each phase timer expires in turn.
- WHIGH→WSETUP: more command writes remain.
- WHIGH→PGAP: the last command write has been issued.
- PGAP→PREAD: the output-enable setup time has elapsed.
- PREAD→DONE: the read matches, or the read budget is used up.
- PREAD→PGAP: a lane is still busy and reads remain in the budget.
- DONE→IDLE: always, after one cycle.

Top module: `pflash_cmd_sequencer`

## Requirements
- R1: After reset, all chip selects, write enables and output enable are high, fl_drive is 0, and busy, ack and timeout_flag are 0.
- R2: Operation code 0 (program) issues exactly four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then req_data to req_addr. Each code byte is replicated on every byte lane.
- R3: Operation code 1 (sector erase) issues six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h@req_addr. The top three address bits of req_addr select the sector.
- R4: Operation code 2 (chip erase) issues the same six writes, except that the last one is 10h to 5555h.
- R5: Each write holds the strobe high with chip select low for ceil(SU_NS·CLK_MHZ/1000) cycles (at least 1), then holds the strobe low for ceil(WP_NS·CLK_MHZ/1000) cycles. Consecutive strobes are separated by ceil(WPH_NS·CLK_MHZ/1000) plus the setup count of high cycles. Address and data are stable while the strobe is low.
- R6: Only the lanes set in req_lanes have their chip select and write enable driven low. Lane i is data bits 8i+7..8i.
- R7: After the last write, and between reads, output enable stays high for WPH (after the last write only) plus ceil(OES_NS·CLK_MHZ/1000) cycles. Each read holds output enable low for ceil(OE_NS·CLK_MHZ/1000) cycles. fl_drive is 0 whenever output enable is low.
- R8: The operation completes on the first read where bit 7 of every enabled lane equals the expected value: req_data for a program, FFh for an erase. Disabled lanes are ignored. The operation then acknowledges with ack_ok=1.
- R9: If poll_limit reads (0 counts as 1) all show a busy enabled lane, the operation aborts with ack_ok=0 and timeout_flag=1.
- R10: ack is high for exactly one cycle, in the cycle right after the deciding read. timeout_flag is cleared when the next request is accepted.
- R11: A request is accepted only in IDLE. req_valid while busy is ignored.
- R12: Operation code 3, or a lane mask of 0, is rejected. ack is raised in the cycle after acceptance with ack_ok=0 and timeout_flag=0, and there is no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | ADDR_W | Target address (program word / sector / poll location) |
| req_data | input | 8*LANES | Program data |
| req_lanes | input | LANES | Participating byte lanes |
| poll_limit | input | LIMIT_W | Maximum number of status reads (0 means 1) |
| busy | output | 1 | High outside IDLE |
| ack | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | Pass status, valid with ack |
| timeout_flag | output | 1 | Last operation aborted on the read budget |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8*LANES | Flash write data |
| fl_drive | output | 1 | Enables the data pad drivers |
| fl_rdata | input | 8*LANES | Flash read data |
| fl_ce_n | output | LANES | Per-lane chip selects, active low |
| fl_we_n | output | LANES | Per-lane write enables, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest case to reach is a status read where some enabled lanes have finished while another is still busy. In the same read, a disabled lane shows the inverted bit 7, which would fail the check if it were not masked. It is hardest when this coincides with the exact last read allowed by the budget. The bench flash model gives each lane its own count of busy reads and always drives disabled lanes with the complement of the expected byte. The sweep walks every lane mask under each operation code, and targeted cases then put the busiest lane one read inside and one read outside the budget.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WLOW,
        ST_WHIGH,
        ST_PGAP,
        ST_PREAD,
        ST_DONE
    } state_e;

    localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  CODE_AA     = 8'hAA;
    localparam logic [7:0]  CODE_55     = 8'h55;
    localparam logic [7:0]  CODE_PROG   = 8'hA0;
    localparam logic [7:0]  CODE_ERASE  = 8'h80;
    localparam logic [7:0]  CODE_SECT   = 8'h30;
    localparam logic [7:0]  CODE_CHIP   = 8'h10;

    // Round a nanosecond interval up to whole clocks, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pflash_cmd_table.sv
module pflash_cmd_table
    import pflash_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 4
) (
    input  op_e                 op,
    input  logic [2:0]          step,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [8*LANES-1:0]  tgt_data,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [8*LANES-1:0]  wr_data,
    output logic                last_step
);
    localparam logic [ADDR_W-1:0] ADR_A = {{(ADDR_W-16){1'b0}}, UNLK_ADDR_A};
    localparam logic [ADDR_W-1:0] ADR_B = {{(ADDR_W-16){1'b0}}, UNLK_ADDR_B};

    logic [7:0] code;
    logic       use_tgt_data;

    always_comb begin
        code         = CODE_AA;
        wr_addr      = ADR_A;
        use_tgt_data = 1'b0;
        unique case (step)
            3'd0: begin code = CODE_AA; wr_addr = ADR_A; end
            3'd1: begin code = CODE_55; wr_addr = ADR_B; end
            3'd2: begin
                code    = (op == OP_PROG) ? CODE_PROG : CODE_ERASE;
                wr_addr = ADR_A;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    use_tgt_data = 1'b1;
                    wr_addr      = tgt_addr;
                end else begin
                    code    = CODE_AA;
                    wr_addr = ADR_A;
                end
            end
            3'd4: begin code = CODE_55; wr_addr = ADR_B; end
            3'd5: begin
                if (op == OP_CHIP) begin
                    code    = CODE_CHIP;
                    wr_addr = ADR_A;
                end else begin
                    code    = CODE_SECT;
                    wr_addr = tgt_addr;
                end
            end
            default: begin code = CODE_AA; wr_addr = ADR_A; end
        endcase
    end

    assign wr_data   = use_tgt_data ? tgt_data : {LANES{code}};
    assign last_step = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/pflash_phase_timer.sv
module pflash_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);

    // R5: a phase is never loaded with zero length
    assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/pflash_lane_check.sv
module pflash_lane_check #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] rdata,
    input  logic [8*LANES-1:0] expect_data,
    input  logic [LANES-1:0]   lanes,
    output logic               all_done
);
    logic [LANES-1:0] lane_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_ok[i] = !lanes[i] || (rdata[8*i+7] == expect_data[8*i+7]);
    end

    assign all_done = &lane_ok;

endmodule

// File: rtl/pflash_cmd_sequencer.sv
module pflash_cmd_sequencer
    import pflash_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int LANES   = 4,
    parameter int CLK_MHZ = 125,
    parameter int SU_NS   = 0,
    parameter int WP_NS   = 40,
    parameter int WPH_NS  = 20,
    parameter int OES_NS  = 10,
    parameter int OE_NS   = 30,
    parameter int LIMIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [8*LANES-1:0]  req_data,
    input  logic [LANES-1:0]    req_lanes,
    input  logic [LIMIT_W-1:0]  poll_limit,
    output logic                busy,
    output logic                ack,
    output logic                ack_ok,
    output logic                timeout_flag,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [8*LANES-1:0]  fl_wdata,
    output logic                fl_drive,
    input  logic [8*LANES-1:0]  fl_rdata,
    output logic [LANES-1:0]    fl_ce_n,
    output logic [LANES-1:0]    fl_we_n,
    output logic                fl_oe_n
);
    localparam int DW    = 8 * LANES;
    localparam int T_SU  = ns_to_cyc(SU_NS,  CLK_MHZ);
    localparam int T_WP  = ns_to_cyc(WP_NS,  CLK_MHZ);
    localparam int T_WPH = ns_to_cyc(WPH_NS, CLK_MHZ);
    localparam int T_OES = ns_to_cyc(OES_NS, CLK_MHZ);
    localparam int T_OE  = ns_to_cyc(OE_NS,  CLK_MHZ);
    localparam int T_M1  = (T_SU  > T_WP)  ? T_SU  : T_WP;
    localparam int T_M2  = (T_WPH > T_OES) ? T_WPH : T_OES;
    localparam int T_M3  = (T_M1  > T_M2)  ? T_M1  : T_M2;
    localparam int T_MAX = (T_M3  > T_OE)  ? T_M3  : T_OE;
    localparam int TMR_W = $clog2(T_MAX + 1);

    // ---------------- state and context ----------------
    state_e               state, state_n;
    op_e                  op_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DW-1:0]        data_q;
    logic [LANES-1:0]     lanes_q;
    logic [LIMIT_W-1:0]   limit_q;
    logic [LIMIT_W-1:0]   poll_cnt;
    logic [2:0]           step_q;
    logic                 ok_q, tmo_q;

    // ---------------- control strobes from next-state logic ----------------
    logic                 accept, step_inc, poll_inc, fin_ok, fin_tmo;
    logic                 tmr_load, tmr_last;
    logic [TMR_W-1:0]     tmr_len;

    // ---------------- helper datapath ----------------
    logic [ADDR_W-1:0]    cmd_addr;
    logic [DW-1:0]        cmd_data;
    logic                 cmd_last;
    logic [DW-1:0]        expect_data;
    logic                 lanes_done;
    logic [LIMIT_W-1:0]   eff_limit;
    logic                 budget_gone;

    pflash_cmd_table #(.ADDR_W(ADDR_W), .LANES(LANES)) u_table (
        .op        (op_q),
        .step      (step_q),
        .tgt_addr  (addr_q),
        .tgt_data  (data_q),
        .wr_addr   (cmd_addr),
        .wr_data   (cmd_data),
        .last_step (cmd_last)
    );

    pflash_phase_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    assign expect_data = (op_q == OP_PROG) ? data_q : {DW{1'b1}};

    pflash_lane_check #(.LANES(LANES)) u_check (
        .rdata       (fl_rdata),
        .expect_data (expect_data),
        .lanes       (lanes_q),
        .all_done    (lanes_done)
    );

    assign eff_limit   = (limit_q == '0) ? LIMIT_W'(1) : limit_q;
    assign budget_gone = ({1'b0, poll_cnt} + (LIMIT_W+1)'(1)) >= {1'b0, eff_limit};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // ---------------- context registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            lanes_q  <= '0;
            limit_q  <= '0;
            poll_cnt <= '0;
            step_q   <= '0;
            ok_q     <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            if (accept) begin
                op_q     <= op_e'(req_op);
                addr_q   <= req_addr;
                data_q   <= req_data;
                lanes_q  <= req_lanes;
                limit_q  <= poll_limit;
                poll_cnt <= '0;
                step_q   <= '0;
                ok_q     <= 1'b0;
                tmo_q    <= 1'b0;
            end
            if (step_inc) step_q   <= step_q + 3'd1;
            if (poll_inc) poll_cnt <= poll_cnt + LIMIT_W'(1);
            if (fin_ok)   ok_q     <= 1'b1;
            if (fin_tmo)  tmo_q    <= 1'b1;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n  = state;
        accept   = 1'b0;
        step_inc = 1'b0;
        poll_inc = 1'b0;
        fin_ok   = 1'b0;
        fin_tmo  = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(T_SU);
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (op_e'(req_op) == OP_RSVD || req_lanes == '0) begin
                        state_n = ST_DONE;
                    end else begin
                        state_n  = ST_WSETUP;
                        tmr_load = 1'b1;
                        tmr_len  = TMR_W'(T_SU);
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_last) begin
                    state_n  = ST_WLOW;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(T_WP);
                end
            end
            ST_WLOW: begin
                if (tmr_last) begin
                    state_n  = ST_WHIGH;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(T_WPH);
                end
            end
            ST_WHIGH: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (cmd_last) begin
                        state_n = ST_PGAP;
                        tmr_len = TMR_W'(T_OES);
                    end else begin
                        state_n  = ST_WSETUP;
                        step_inc = 1'b1;
                        tmr_len  = TMR_W'(T_SU);
                    end
                end
            end
            ST_PGAP: begin
                if (tmr_last) begin
                    state_n  = ST_PREAD;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(T_OE);
                end
            end
            ST_PREAD: begin
                if (tmr_last) begin
                    if (lanes_done) begin
                        state_n = ST_DONE;
                        fin_ok  = 1'b1;
                    end else if (budget_gone) begin
                        state_n = ST_DONE;
                        fin_tmo = 1'b1;
                    end else begin
                        state_n  = ST_PGAP;
                        poll_inc = 1'b1;
                        tmr_load = 1'b1;
                        tmr_len  = TMR_W'(T_OES);
                    end
                end
            end
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        fl_ce_n  = '1;
        fl_we_n  = '1;
        fl_oe_n  = 1'b1;
        fl_drive = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        ack      = 1'b0;
        ack_ok   = 1'b0;
        unique case (state)
            ST_WSETUP, ST_WHIGH: begin
                fl_ce_n  = ~lanes_q;
                fl_drive = 1'b1;
                fl_addr  = cmd_addr;
                fl_wdata = cmd_data;
            end
            ST_WLOW: begin
                fl_ce_n  = ~lanes_q;
                fl_we_n  = ~lanes_q;
                fl_drive = 1'b1;
                fl_addr  = cmd_addr;
                fl_wdata = cmd_data;
            end
            ST_PGAP: begin
                fl_ce_n = ~lanes_q;
                fl_addr = addr_q;
            end
            ST_PREAD: begin
                fl_ce_n = ~lanes_q;
                fl_oe_n = 1'b0;
                fl_addr = addr_q;
            end
            ST_DONE: begin
                ack    = 1'b1;
                ack_ok = ok_q;
            end
            default: ;
        endcase
    end

    assign busy         = (state != ST_IDLE);
    assign timeout_flag = tmo_q;

    // ---------------- assertions ----------------
    assert_we_inside_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~fl_we_n) & fl_ce_n) == '0);

    assert_read_not_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_drive && fl_we_n == '1));

    assert_strobe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WLOW) |=> ($stable(fl_addr) && $stable(fl_wdata)));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && !busy));

    assert_ctx_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lanes_q) && $stable(addr_q) && $stable(op_q)));

    assert_timeout_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && timeout_flag) |-> !ack_ok);

endmodule

// File: tb/pflash_cmd_sequencer_bench.sv
module pflash_cmd_sequencer_bench;

    localparam int MHZ = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_lanes = '0;
    logic [7:0]  poll_limit = '0;
    logic        busy, ack, ack_ok, timeout_flag, fl_drive, fl_oe_n;
    logic [18:0] fl_addr;
    logic [31:0] fl_wdata, fl_rdata;
    logic [3:0]  fl_ce_n, fl_we_n;

    always #4 clk = ~clk;

    pflash_cmd_sequencer u_pflash_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes),
        .poll_limit(poll_limit), .busy(busy), .ack(ack), .ack_ok(ack_ok),
        .timeout_flag(timeout_flag), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_drive(fl_drive), .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    function automatic int cyc(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    int t_su, t_wp, t_wph, t_oes, t_oe;
    int n_checks = 0, n_errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit cond, input string req, input int act, input int expv);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // ---------------- flash model ----------------
    logic [31:0] exp_w = '0;
    logic [3:0]  en_m = '0;
    int          bsy [4];
    int          rd_cnt;

    always @* begin
        for (int i = 0; i < 4; i++) begin
            if (en_m[i] && rd_cnt >= bsy[i])
                fl_rdata[8*i +: 8] = exp_w[8*i +: 8];
            else
                fl_rdata[8*i +: 8] = ~exp_w[8*i +: 8];
        end
    end

    // ---------------- bus monitor (samples at negedge) ----------------
    bit          clr = 1'b0;
    int          wr_n, rd_n, ack_n, bus_act, lo_run, hi_run, gap, oe_run;
    bit          prev_we_low, prev_oe_low, ack_prev_oe, ack_ok_s, tmo_s;
    logic [18:0] log_a [16];
    logic [31:0] log_d [16];
    logic [3:0]  log_m [16];
    int          log_lo [16], log_hi [16], log_gap [16], log_oe [16];
    logic [18:0] cap_a;
    logic [31:0] cap_d;
    logic [3:0]  cap_m;

    always @(negedge clk) begin
        bit we_low, oe_low;
        if (clr) begin
            wr_n = 0; rd_n = 0; rd_cnt = 0; ack_n = 0; bus_act = 0;
            lo_run = 0; hi_run = 0; gap = 0; oe_run = 0;
            prev_we_low = 0; prev_oe_low = 0;
        end else begin
            we_low = (fl_we_n != 4'hF);
            oe_low = !fl_oe_n;
            if (fl_ce_n != 4'hF) bus_act++;
            if (we_low) begin
                if (!prev_we_low && wr_n < 16) log_hi[wr_n] = hi_run;
                lo_run++; cap_a = fl_addr; cap_d = fl_wdata; cap_m = ~fl_we_n;
                hi_run = 0; gap = 0;
            end else begin
                if (prev_we_low && wr_n < 16) begin
                    log_a[wr_n] = cap_a; log_d[wr_n] = cap_d;
                    log_m[wr_n] = cap_m; log_lo[wr_n] = lo_run;
                    wr_n++; lo_run = 0;
                end
                if (fl_ce_n != 4'hF && !oe_low) hi_run++;
                if (fl_ce_n != 4'hF && !oe_low) gap++;
            end
            if (oe_low) begin
                if (!prev_oe_low && rd_n < 16) log_gap[rd_n] = gap;
                oe_run++; gap = 0;
            end else if (prev_oe_low) begin
                if (rd_n < 16) log_oe[rd_n] = oe_run;
                rd_n++; rd_cnt++; oe_run = 0;
            end
            if (ack) begin
                ack_n++; ack_ok_s = ack_ok; tmo_s = timeout_flag;
                ack_prev_oe = prev_oe_low;
            end
            prev_we_low = we_low;
            prev_oe_low = oe_low;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic issue(input int op, input logic [3:0] lanes, input logic [18:0] a,
                         input logic [31:0] d, input int lim);
        @(posedge clk); #1;
        clr = 1'b1;
        req_valid = 1'b1; req_op = 2'(op); req_lanes = lanes;
        req_addr = a; req_data = d; poll_limit = 8'(lim);
        @(posedge clk); #1;
        clr = 1'b0; req_valid = 1'b0;
    endtask

    task automatic run_op(input int op, input logic [3:0] lanes, input logic [18:0] a,
                          input logic [31:0] d, input int lim,
                          input int b0, input int b1, input int b2, input int b3,
                          input bit inject);
        logic [18:0] ea [6];
        logic [7:0]  ec [6];
        int n, mism, maxb, need, eff, exp_rd, waited;
        bit pass, tbad;
        string rq;
        exp_w = (op == 0) ? d : 32'hFFFF_FFFF;
        en_m = lanes;
        bsy[0] = b0; bsy[1] = b1; bsy[2] = b2; bsy[3] = b3;
        issue(op, lanes, a, d, lim);
        @(negedge clk);
        chk(timeout_flag == 1'b0 && busy == 1'b1, "R10 flag cleared on accept", int'(timeout_flag), 0);
        if (inject) begin
            repeat (8) @(posedge clk);
            #1 req_valid = 1'b1; req_op = 2'd2; req_lanes = 4'hF;
            repeat (3) @(posedge clk);
            #1 req_valid = 1'b0;
        end
        waited = 0;
        while (ack_n == 0 && waited < 5000) begin @(posedge clk); waited++; end
        repeat (3) @(posedge clk);

        ea[0] = 19'h5555; ec[0] = 8'hAA;
        ea[1] = 19'h2AAA; ec[1] = 8'h55;
        ea[2] = 19'h5555; ec[2] = (op == 0) ? 8'hA0 : 8'h80;
        ea[3] = 19'h5555; ec[3] = 8'hAA;
        ea[4] = 19'h2AAA; ec[4] = 8'h55;
        ea[5] = (op == 1) ? a : 19'h5555; ec[5] = (op == 1) ? 8'h30 : 8'h10;
        n = (op == 0) ? 4 : 6;
        rq = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
        chk(wr_n == n, {rq, " write count"}, wr_n, n);
        mism = 0;
        for (int k = 0; k < n && k < wr_n; k++) begin
            if (op == 0 && k == 3) begin
                if (log_a[k] != a || log_d[k] != d) mism++;
            end else if (log_a[k] != ea[k] || log_d[k] != {4{ec[k]}}) mism++;
        end
        chk(mism == 0, {rq, " write sequence"}, mism, 0);
        mism = 0;
        for (int k = 0; k < wr_n && k < 16; k++) if (log_m[k] != lanes) mism++;
        chk(mism == 0, inject ? "R11 busy request ignored" : "R6 lane strobes", mism, 0);
        tbad = 0;
        for (int k = 0; k < wr_n && k < 16; k++) begin
            if (log_lo[k] != t_wp) tbad = 1;
            if (log_hi[k] != ((k == 0) ? t_su : t_wph + t_su)) tbad = 1;
        end
        chk(!tbad, "R5 strobe timing", log_lo[0], t_wp);

        maxb = 0;
        for (int i = 0; i < 4; i++) if (lanes[i] && bsy[i] > maxb) maxb = bsy[i];
        need = maxb + 1;
        eff = (lim == 0) ? 1 : lim;
        pass = (need <= eff);
        exp_rd = pass ? need : eff;
        chk(rd_n == exp_rd, pass ? "R8 read count" : "R9 read count", rd_n, exp_rd);
        chk(ack_ok_s == pass, pass ? "R8 pass status" : "R9 fail status", int'(ack_ok_s), int'(pass));
        chk(tmo_s == !pass, "R9 timeout flag", int'(tmo_s), int'(!pass));
        tbad = 0;
        for (int k = 0; k < rd_n && k < 16; k++) begin
            if (log_oe[k] != t_oe) tbad = 1;
            if (log_gap[k] != ((k == 0) ? t_wph + t_oes : t_oes)) tbad = 1;
        end
        chk(!tbad, "R7 read timing", log_gap[0], t_wph + t_oes);
        chk(ack_n == 1 && ack_prev_oe, "R10 single ack after read", ack_n, 1);
    endtask

    task automatic run_reject(input int op, input logic [3:0] lanes);
        en_m = lanes;
        issue(op, lanes, 19'h12345, 32'h1234_5678, 4);
        @(negedge clk);
        chk(ack && !ack_ok && !timeout_flag, "R12 reject ack", int'({ack, ack_ok, timeout_flag}), 4);
        @(negedge clk);
        chk(!ack && !busy, "R10 ack one cycle", int'(ack), 0);
        repeat (4) @(negedge clk);
        chk(bus_act == 0 && wr_n == 0, "R12 no bus activity", bus_act, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        t_su = cyc(0); t_wp = cyc(40); t_wph = cyc(20); t_oes = cyc(10); t_oe = cyc(30);
        for (int i = 0; i < 4; i++) bsy[i] = 0;
        repeat (3) @(negedge clk);
        chk(fl_ce_n == 4'hF && fl_we_n == 4'hF && fl_oe_n && !fl_drive,
            "R1 bus idle in reset", int'({fl_ce_n, fl_we_n}), 8'hFF);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !ack && !timeout_flag, "R1 status idle", int'({busy, ack, timeout_flag}), 0);

        // Sweep: every operation over every lane mask, staggered lane busy counts
        for (int op = 0; op < 3; op++) begin
            for (int m = 1; m < 16; m++) begin
                run_op(op, 4'(m), 19'(m * 'h9D71 + op * 'h11111),
                       32'hC3A5_5A3C ^ 32'(m * 32'h1F2E_3D4C) ^ 32'(op << 7), 8,
                       (0 + m + op) % 3, (1 + m + op) % 3, (2 + m + op) % 3, (3 + m + op) % 3, 1'b0);
            end
        end

        // Budget and masking corners
        run_op(0, 4'hF, 19'h0_0100, 32'h8000_7F80, 3, 5, 0, 0, 1, 1'b0); // R9: timeout after 3 reads
        run_op(1, 4'b0101, 19'h5_1234, 32'h0, 0, 0, 2, 0, 9, 1'b0);     // R8: busy lanes disabled, limit 0
        run_op(2, 4'b1000, 19'h0, 32'h0, 0, 0, 0, 0, 4, 1'b0);          // R9: limit 0 means one read
        run_op(0, 4'b0110, 19'h7_FFFF, 32'h0080_8000, 7, 0, 7, 0, 0, 1'b0); // R9: one read short
        run_op(0, 4'b0110, 19'h7_FFFF, 32'h0080_8000, 8, 0, 7, 0, 0, 1'b0); // R8: exactly on budget
        run_op(1, 4'b0011, 19'h3_0040, 32'h0, 8, 1, 2, 0, 0, 1'b1);     // R11: request while busy

        // Rejections
        run_reject(3, 4'hF);
        run_reject(0, 4'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule